// File: doc/BRIEF.md
# Associative Minimum Spanning Tree Engine

This block builds a minimum spanning tree over a small undirected graph of up to `N_NODES` vertices. Each vertex has its own cell. A cell holds a set tag, which marks it as unseen, a candidate or a tree member. It also holds the lightest edge that currently links it to the tree and the index of the tree vertex at the other end of that edge. The engine works in rounds. In each round it broadcasts one weight-table row to every cell, and all cells relax their recorded edge in parallel. A global minimum reduction with a pick-one step then selects the next vertex. No sorted list or priority queue of edges is kept.

The host fills a symmetric weight table through a write port. A weight of zero means no edge. The host then pulses `start` with a root index. Each tree edge appears on a valid/ready output as (parent, child, weight). When the candidate set is empty, the engine raises `done`. If some vertex was never reached, it also raises `disconnected`.

Top module: `assoc_mst_engine`

## Requirements
- R1: A write with `wr_en` high stores the 8-bit unsigned `wr_weight` at both (row, col) and (col, row) of the table. A stored 0 means the two vertices have no edge.
- R2: A `start` pulse while idle begins a run with `start_root` as the only tree vertex. `busy` is high from the next cycle until the run ends.
- R3: A `start` pulse while `busy` is high is ignored. The run in progress and its edges are unchanged.
- R4: Each emitted edge joins a tree vertex (parent) to a vertex outside the tree (child). Its weight is the smallest recorded candidate weight at that step, which yields a minimum spanning tree.
- R5: When several candidates share the minimum weight, the one with the lowest vertex index is chosen.
- R6: A candidate's recorded edge is replaced only by a strictly lighter edge from a newly joined vertex. An equal or heavier edge leaves the old parent in place.
- R7: While `edge_valid` is high and `edge_ready` is low, `edge_valid` and all edge fields hold their values.
- R8: A connected graph gives exactly N_NODES-1 edges, then `done` high with `disconnected` low. `done` stays high with `edge_valid` low until the next start.
- R9: If candidates run out while a vertex is still outside the tree, the engine emits only the reachable tree's edges. It then raises `done` together with `disconnected`.
- R10: After reset, `edge_valid`, `busy`, `done` and `disconnected` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_row | input | IW | Table write first vertex |
| wr_col | input | IW | Table write second vertex |
| wr_weight | input | W_BITS | Edge weight, 0 = no edge |
| start | input | 1 | Start pulse |
| start_root | input | IW | Root vertex for the run |
| edge_valid | output | 1 | Tree edge offered |
| edge_ready | input | 1 | Sink accepts the offered edge |
| edge_parent | output | IW | Tree-side vertex of the edge |
| edge_child | output | IW | Newly joined vertex |
| edge_weight | output | W_BITS | Edge weight |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| disconnected | output | 1 | Run ended with unreached vertices |

## Verification
Two functions can land on the same clock edge: a table write and the `start` that launches a run. The bench provokes this by writing a light edge at the root's row in the very cycle of the start pulse. The reference model includes that edge, because the first row broadcast happens one cycle later. A second overlap is a `start` pulse that arrives while an edge is being held under back-pressure. The engine must ignore it, and every later edge is judged against the model's list for the original root.

// File: rtl/amst_pkg.sv
package amst_pkg;
  typedef enum logic [1:0] {
    TAG_UNSEEN = 2'd0,
    TAG_CAND   = 2'd1,
    TAG_TREE   = 2'd2
  } node_tag_e;
endpackage

// File: rtl/amst_weight_table.sv
module amst_weight_table #(
  parameter int N_NODES = 16,
  parameter int W_BITS  = 8,
  localparam int IW = $clog2(N_NODES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_row,
  input  logic [IW-1:0]     wr_col,
  input  logic [W_BITS-1:0] wr_weight,
  input  logic [IW-1:0]     rd_idx,
  output logic [W_BITS-1:0] rd_row [N_NODES]
);
  logic [W_BITS-1:0] mem [N_NODES][N_NODES];

  // both mirror entries written on one strobe (R1)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_row][wr_col] <= wr_weight;
      mem[wr_col][wr_row] <= wr_weight;
    end
  end

  always_comb begin
    for (int k = 0; k < N_NODES; k++) rd_row[k] = mem[rd_idx][k];
  end
endmodule

// File: rtl/amst_node_cell.sv
module amst_node_cell import amst_pkg::*; #(
  parameter int N_NODES = 16,
  parameter int W_BITS  = 8,
  localparam int IW = $clog2(N_NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              is_root,
  input  logic              relax_en,
  input  logic              take,
  input  logic [W_BITS-1:0] bcast_w,
  input  logic [IW-1:0]     bcast_src,
  output node_tag_e         tag,
  output logic [W_BITS-1:0] best_w,
  output logic [IW-1:0]     best_par
);
  node_tag_e         tag_d;
  logic [W_BITS-1:0] best_d;
  logic [IW-1:0]     par_d;
  logic              upd_en;
  logic              lighter;

  assign lighter = (bcast_w != '0) && (tag == TAG_UNSEEN || bcast_w < best_w);
  assign upd_en  = init | take | relax_en;

  always_comb begin
    tag_d  = tag;
    best_d = best_w;
    par_d  = best_par;
    if (init) begin
      tag_d  = is_root ? TAG_TREE : TAG_UNSEEN;
      best_d = '0;
      par_d  = '0;
    end else if (take) begin
      tag_d = TAG_TREE;
    end else if (relax_en && tag != TAG_TREE && lighter) begin
      tag_d  = TAG_CAND;
      best_d = bcast_w;
      par_d  = bcast_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag      <= TAG_UNSEEN;
      best_w   <= '0;
      best_par <= '0;
    end else if (upd_en) begin
      tag      <= tag_d;
      best_w   <= best_d;
      best_par <= par_d;
    end
  end

  // a tree member leaves the tree only on a new run (R4)
  p_tree_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tag == TAG_TREE && !init) |=> tag == TAG_TREE);

  // a candidate's recorded weight never grows during a run (R6)
  p_best_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag == TAG_CAND && !init && !take) |=> best_w <= $past(best_w));
endmodule

// File: rtl/amst_min_pick.sv
module amst_min_pick import amst_pkg::*; #(
  parameter int N_NODES = 16,
  parameter int W_BITS  = 8,
  localparam int IW = $clog2(N_NODES)
) (
  input  node_tag_e         tags  [N_NODES],
  input  logic [W_BITS-1:0] bests [N_NODES],
  output logic              found,
  output logic [IW-1:0]     pick_idx
);
  logic [W_BITS-1:0] min_w;

  // ascending scan with strict compare keeps lowest index on ties (R5)
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    min_w    = '1;
    for (int i = 0; i < N_NODES; i++) begin
      if (tags[i] == TAG_CAND && (!found || bests[i] < min_w)) begin
        found    = 1'b1;
        pick_idx = IW'(i);
        min_w    = bests[i];
      end
    end
  end
endmodule

// File: rtl/assoc_mst_engine.sv
module assoc_mst_engine import amst_pkg::*; #(
  parameter int N_NODES = 16,
  parameter int W_BITS  = 8,
  localparam int IW = $clog2(N_NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_row,
  input  logic [IW-1:0]     wr_col,
  input  logic [W_BITS-1:0] wr_weight,
  input  logic              start,
  input  logic [IW-1:0]     start_root,
  output logic              edge_valid,
  input  logic              edge_ready,
  output logic [IW-1:0]     edge_parent,
  output logic [IW-1:0]     edge_child,
  output logic [W_BITS-1:0] edge_weight,
  output logic              busy,
  output logic              done,
  output logic              disconnected
);
  localparam int CW = $clog2(N_NODES) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RELAX, S_PICK, S_OFFER} st_e;

  st_e               st_q, st_d;
  logic [IW-1:0]     join_q, join_d;
  logic              ev_q, ev_d;
  logic [IW-1:0]     ep_q, ep_d, ec_q, ec_d;
  logic [W_BITS-1:0] ew_q, ew_d;
  logic              done_q, done_d, disc_q, disc_d;
  logic [CW-1:0]     sent_q, sent_d;

  logic              init, relax_en, found, all_tree;
  logic [IW-1:0]     pick_idx;
  node_tag_e         tag_v  [N_NODES];
  logic [W_BITS-1:0] best_v [N_NODES];
  logic [IW-1:0]     par_v  [N_NODES];
  logic [W_BITS-1:0] row_w  [N_NODES];

  amst_weight_table #(.N_NODES(N_NODES), .W_BITS(W_BITS)) u_table (
    .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_weight(wr_weight), .rd_idx(join_q), .rd_row(row_w)
  );

  for (genvar k = 0; k < N_NODES; k++) begin : g_cell
    amst_node_cell #(.N_NODES(N_NODES), .W_BITS(W_BITS)) u_cell (
      .clk(clk), .rst_n(rst_n), .init(init),
      .is_root(start_root == IW'(k)),
      .relax_en(relax_en),
      .take(st_q == S_PICK && found && pick_idx == IW'(k)),
      .bcast_w(row_w[k]), .bcast_src(join_q),
      .tag(tag_v[k]), .best_w(best_v[k]), .best_par(par_v[k])
    );
  end

  amst_min_pick #(.N_NODES(N_NODES), .W_BITS(W_BITS)) u_pick (
    .tags(tag_v), .bests(best_v), .found(found), .pick_idx(pick_idx)
  );

  always_comb begin
    all_tree = 1'b1;
    for (int k = 0; k < N_NODES; k++)
      if (tag_v[k] != TAG_TREE) all_tree = 1'b0;
  end

  always_comb begin
    st_d     = st_q;
    join_d   = join_q;
    ev_d     = ev_q;
    ep_d     = ep_q;
    ec_d     = ec_q;
    ew_d     = ew_q;
    done_d   = done_q;
    disc_d   = disc_q;
    sent_d   = sent_q;
    init     = 1'b0;
    relax_en = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        init   = 1'b1;
        join_d = start_root;
        done_d = 1'b0;
        disc_d = 1'b0;
        sent_d = '0;
        st_d   = S_RELAX;
      end
      S_RELAX: begin
        relax_en = 1'b1;
        st_d     = S_PICK;
      end
      S_PICK: if (found) begin
        ep_d   = par_v[pick_idx];
        ec_d   = pick_idx;
        ew_d   = best_v[pick_idx];
        join_d = pick_idx;
        ev_d   = 1'b1;
        st_d   = S_OFFER;
      end else begin
        done_d = 1'b1;
        disc_d = !all_tree;
        st_d   = S_IDLE;
      end
      S_OFFER: if (edge_ready) begin
        ev_d   = 1'b0;
        sent_d = sent_q + 1'b1;
        st_d   = S_RELAX;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      join_q <= '0;
      ev_q   <= 1'b0;
      ep_q   <= '0;
      ec_q   <= '0;
      ew_q   <= '0;
      done_q <= 1'b0;
      disc_q <= 1'b0;
      sent_q <= '0;
    end else begin
      st_q   <= st_d;
      join_q <= join_d;
      ev_q   <= ev_d;
      ep_q   <= ep_d;
      ec_q   <= ec_d;
      ew_q   <= ew_d;
      done_q <= done_d;
      disc_q <= disc_d;
      sent_q <= sent_d;
    end
  end

  assign edge_valid   = ev_q;
  assign edge_parent  = ep_q;
  assign edge_child   = ec_q;
  assign edge_weight  = ew_q;
  assign busy         = (st_q != S_IDLE);
  assign done         = done_q;
  assign disconnected = disc_q;

  p_hold_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_valid && !edge_ready) |=> edge_valid && $stable(edge_parent)
      && $stable(edge_child) && $stable(edge_weight));

  p_edge_weight_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_valid |-> edge_weight != '0);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !edge_valid && !busy);

  p_edge_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !disconnected) |-> sent_q == CW'(N_NODES - 1));

  p_disc_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disconnected |-> done);

  p_busy_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_valid && !edge_ready && start) |=> edge_valid);
endmodule

// File: tb/tb_assoc_mst_engine.sv
`timescale 1ns/1ps
module tb_assoc_mst_engine;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_row = '0, wr_col = '0;
  logic [7:0] wr_weight = '0;
  logic start = 1'b0;
  logic [IW-1:0] start_root = '0;
  logic edge_ready = 1'b0;
  logic edge_valid, busy, done, disconnected;
  logic [IW-1:0] edge_parent, edge_child;
  logic [7:0] edge_weight;

  assoc_mst_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_weight(wr_weight), .start(start), .start_root(start_root),
    .edge_valid(edge_valid), .edge_ready(edge_ready), .edge_parent(edge_parent),
    .edge_child(edge_child), .edge_weight(edge_weight), .busy(busy),
    .done(done), .disconnected(disconnected)
  );

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int unsigned lcg = 32'h1234_5678;
  int mw [N][N];
  int exp_p[$], exp_c[$], exp_w[$];
  bit exp_disc;

  function automatic int rnd(input int m);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) & 32'h7fff) % m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic mdl_write(input int r, input int c, input int w);
    mw[r][c] = w;
    mw[c][r] = w;
  endtask

  task automatic wr(input int r, input int c, input int w);
    @(negedge clk);
    wr_en = 1'b1; wr_row = IW'(r); wr_col = IW'(c); wr_weight = 8'(w);
    mdl_write(r, c, w);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int r = 0; r < N; r++)
      for (int c = r; c < N; c++) wr(r, c, 0);
  endtask

  // behavioural reference: set tags, strict relaxation, lowest-index ties
  task automatic model(input int root);
    bit intree [N];
    bit cand [N];
    int best [N];
    int par [N];
    int j, sel;
    exp_p.delete(); exp_c.delete(); exp_w.delete();
    for (int k = 0; k < N; k++) begin intree[k] = 0; cand[k] = 0; best[k] = 0; par[k] = 0; end
    intree[root] = 1;
    j = root;
    forever begin
      for (int k = 0; k < N; k++)
        if (!intree[k] && mw[j][k] != 0 && (!cand[k] || mw[j][k] < best[k])) begin
          cand[k] = 1; best[k] = mw[j][k]; par[k] = j;
        end
      sel = -1;
      for (int k = 0; k < N; k++)
        if (cand[k] && (sel < 0 || best[k] < best[sel])) sel = k;
      if (sel < 0) break;
      exp_p.push_back(par[sel]); exp_c.push_back(sel); exp_w.push_back(best[sel]);
      intree[sel] = 1; cand[sel] = 0; j = sel;
    end
    exp_disc = 0;
    for (int k = 0; k < N; k++) if (!intree[k]) exp_disc = 1;
  endtask

  task automatic run(input int root, input bit poke, input int rmode,
                     input bit late, input int lr, input int lc, input int lw,
                     input string tg);
    bit held, poked, rdy;
    if (late) mdl_write(lr, lc, lw);
    model(root);
    @(negedge clk);
    start = 1'b1; start_root = IW'(root);
    if (late) begin wr_en = 1'b1; wr_row = IW'(lr); wr_col = IW'(lc); wr_weight = 8'(lw); end
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    held = 0; poked = 0;
    forever begin
      start = 1'b0;
      if (done) break;
      if (held) chk(edge_valid == 1'b1, "R7 valid held", int'(edge_valid), 1);
      if (edge_valid) begin
        if (exp_p.size() == 0) chk(1'b0, "R8 extra edge", int'(edge_child), -1);
        else begin
          chk(int'(edge_parent) == exp_p[0], {tg, " parent"}, int'(edge_parent), exp_p[0]);
          chk(int'(edge_child)  == exp_c[0], {tg, " child"},  int'(edge_child),  exp_c[0]);
          chk(int'(edge_weight) == exp_w[0], {tg, " weight"}, int'(edge_weight), exp_w[0]);
        end
        if (poke && !poked) begin
          start = 1'b1; start_root = IW'((root + 3) % N); poked = 1;
        end
        case (rmode)
          0: rdy = 1;
          1: rdy = (rnd(2) == 0);
          default: rdy = (rnd(4) == 0);
        endcase
        edge_ready = rdy;
        if (rdy && exp_p.size() != 0) begin
          void'(exp_p.pop_front()); void'(exp_c.pop_front()); void'(exp_w.pop_front());
        end
        held = !rdy;
      end else begin
        edge_ready = (rnd(2) == 0);
        held = 0;
      end
      @(negedge clk);
    end
    edge_ready = 1'b0;
    chk(exp_p.size() == 0, "R8 edge count", exp_p.size(), 0);
    chk(disconnected == exp_disc, "R9 disconnected flag", int'(disconnected), int'(exp_disc));
    chk(busy == 1'b0, "R2 busy low at end", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && edge_valid == 1'b0, "R8 done held", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!edge_valid && !busy && !done && !disconnected, "R10 reset state",
        int'({edge_valid, busy, done, disconnected}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!edge_valid && !busy && !done && !disconnected, "R10 after release",
        int'({edge_valid, busy, done, disconnected}), 0);

    // random connected graph, random back-pressure
    clear_all();
    for (int i = 0; i < N - 1; i++) wr(i, i + 1, 1 + rnd(255));
    for (int e = 0; e < 30; e++) begin
      int a, b;
      a = rnd(N); b = rnd(N);
      if (a != b) wr(a, b, 1 + rnd(255));
    end
    run(0, 0, 1, 0, 0, 0, 0, "R4");

    // complete graph of equal weights: ties and no replacement on equal
    clear_all();
    for (int r = 0; r < N; r++)
      for (int c = r + 1; c < N; c++) wr(r, c, 7);
    run(5, 0, 0, 0, 0, 0, 0, "R5/R6");

    // two components, second written with reversed indices
    clear_all();
    for (int i = 0; i < 9; i++) wr(i, i + 1, 10 + i);
    for (int i = 10; i < N - 1; i++) wr(i + 1, i, 3);
    run(2, 0, 1, 0, 0, 0, 0, "R9");
    // run from the reversed-write side, reaching only that part (R1)
    run(N - 1, 0, 0, 0, 0, 0, 0, "R1");

    // star with boundary weights, start poked during a held edge
    clear_all();
    for (int i = 0; i < N - 1; i++) wr(N - 1, i, (i % 2 == 0) ? 255 : 1);
    wr(0, 1, 1);
    run(N - 1, 1, 2, 0, 0, 0, 0, "R3");

    // table write in the same cycle as start
    clear_all();
    for (int i = 0; i < N - 1; i++) wr(i, i + 1, 50 + rnd(100));
    wr(3, 12, 40);
    run(3, 0, 1, 1, 3, 9, 1, "R1");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule